// File: doc/BRIEF.md
# Line-Miss Tracker with Critical-Word-First Response Timing

This block keeps track of cache line misses that are still waiting for their fill. Each entry holds one line address with its security attribute and a short, ordered list of the requests that wanted that line. A new request to a line that already has a miss waiting joins that entry's list and does not start a second miss. A request to a line with no open miss claims a free entry, and the block flags that a new downstream fetch is needed. Requests come either from the upstream requester or from a local prefetcher. A request marked as a snoop is never legal here, and it raises an error flag.

When the fill for an entry arrives, the block walks that entry's list in arrival order and handles one target per cycle. A requester target produces a response that carries its tag, its byte offset and a delay value. The delay is the return latency alone for the word the first target asked for. Every other word gets an extra payload delay. Distance is measured from the first target's offset, wrapping around the line. A prefetcher target produces no response and instead marks the line as prefetched but not yet used. An error on the fill is copied into every response of that fill. Once the last target is handled, the entry is released.

Top module: `mshr_cwf`

## Requirements
- R1: A non-snoop request whose line address and secure bit both equal those of a valid entry that is not being serviced is merged into that entry. In the same cycle `req_new` is 0 and `req_entry` gives that entry.
- R2: A non-snoop request that matches no entry takes the lowest-numbered free entry. In the same cycle `req_new` is 1 and `req_entry` gives that entry. Its offset becomes the entry's reference offset.
- R3: `req_full` is 1 in two cases: the request matches no entry and every entry is valid, or the request matches an entry that already holds NUM_TGT targets. A request seen while `req_full` is 1 is not stored.
- R4: A fill is accepted when `fill_valid` is high, `fill_ready` is high and `fill_entry` names a valid entry. Starting in the cycle after acceptance, the entry's targets come out one per cycle in arrival order, each with its tag and offset.
- R5: For a requester target, `rsp_delay` is RSP_LAT when (offset minus reference offset) modulo LINE_BYTES is zero, and RSP_LAT+PAY_LAT otherwise.
- R6: A target with `req_src` = 1 (prefetch) does not raise `rsp_valid`. In its slot, `pf_valid` is 1 and `pf_line` gives the line address.
- R7: `fill_ready` is 0 while a fill is being serviced. The cycle after the last target, the entry is free, `fill_ready` is 1 again, and no output is raised.
- R8: A request with `req_src` = 2 (snoop) is never stored. `src_err` is 1 in the cycle after it.
- R9: `rsp_error` of every response from a fill equals the `fill_error` value given when that fill was accepted.
- R10: An entry under service is excluded from matching. A request to its line during service is handled as a new miss.
- R11: A fill naming an invalid entry is ignored. It produces no response or prefetch mark, and `fill_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_line | input | LINE_AW | Line address of the request |
| req_secure | input | 1 | Secure attribute of the request |
| req_offset | input | log2(LINE_BYTES) | Byte offset within the line |
| req_src | input | 2 | Source: 0 requester, 1 prefetch, 2 snoop |
| req_tag | input | TAG_W | Requester identifier returned with the response |
| req_full | output | 1 | Request cannot be taken this cycle |
| req_entry | output | log2(NUM_ENT) | Entry the request is merged into or allocates |
| req_new | output | 1 | Request starts a new miss |
| src_err | output | 1 | Illegal snoop-source request seen in the previous cycle |
| fill_valid | input | 1 | Line fill arrives |
| fill_entry | input | log2(NUM_ENT) | Entry the fill belongs to |
| fill_error | input | 1 | Fill carries an error |
| fill_ready | output | 1 | Fill can be accepted |
| rsp_valid | output | 1 | Response to a requester target |
| rsp_tag | output | TAG_W | Tag of the answered target |
| rsp_offset | output | log2(LINE_BYTES) | Offset of the answered target |
| rsp_delay | output | DLY_W | Cycles until the response may be delivered |
| rsp_error | output | 1 | Response carries the fill error |
| pf_valid | output | 1 | Line is marked prefetched-unaccessed |
| pf_line | output | LINE_AW | Line address being marked |

## Verification
The bench builds the block with its defaults: four entries of four targets each, 64-byte lines and latencies of 2 and 3. With only four entries and a random pool of three lines with both secure values, both kinds of stall come up often: running out of entries, and filling the four target slots of one line. Random offsets across the whole line reach both the zero-distance case and the negative distances that have to wrap. Requests sent in the middle of a fill service check that an entry under service is excluded from matching.

// File: rtl/mshr_cwf_pkg.sv
// Shared types for the line-miss tracker.
// Assumes the 2-bit source code set below: requester, prefetcher, snoop.
package mshr_cwf_pkg;
    typedef enum logic [1:0] {
        SRC_REQ   = 2'd0,
        SRC_PF    = 2'd1,
        SRC_SNOOP = 2'd2
    } src_e;
endpackage

// File: rtl/mshr_cwf_lookup.sv
// Associative lookup over all entries: finds the entry that matches on line
// and secure bit, skipping the one under service, and the lowest free entry.
// Assumes at most one matchable entry per line, which allocation keeps true.
module mshr_cwf_lookup #(
    parameter int NUM_ENT = 4,
    parameter int NUM_TGT = 4,
    parameter int LINE_AW = 26,
    localparam int ENT_W  = $clog2(NUM_ENT),
    localparam int CNT_W  = $clog2(NUM_TGT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ent_vld  [NUM_ENT],
    input  logic [LINE_AW-1:0] ent_line [NUM_ENT],
    input  logic               ent_sec  [NUM_ENT],
    input  logic [CNT_W-1:0]   ent_cnt  [NUM_ENT],
    input  logic               svc_busy,
    input  logic [ENT_W-1:0]   svc_ent,
    input  logic [LINE_AW-1:0] q_line,
    input  logic               q_sec,
    output logic               hit,
    output logic [ENT_W-1:0]   hit_ent,
    output logic               hit_slots_full,
    output logic               has_free,
    output logic [ENT_W-1:0]   free_ent
);
    logic [NUM_ENT-1:0] hit_vec;

    // Per-entry compare; the entry being serviced never matches.
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
        assign hit_vec[e] = ent_vld[e] && !(svc_busy && svc_ent == ENT_W'(e))
                            && ent_line[e] == q_line && ent_sec[e] == q_sec;
    end

    // Encode hit index and lowest free index.
    always_comb begin
        hit      = 1'b0;
        hit_ent  = '0;
        has_free = 1'b0;
        free_ent = '0;
        for (int e = NUM_ENT - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                hit     = 1'b1;
                hit_ent = ENT_W'(e);
            end
            if (!ent_vld[e]) begin
                has_free = 1'b1;
                free_ent = ENT_W'(e);
            end
        end
    end

    assign hit_slots_full = ent_cnt[hit_ent] == CNT_W'(NUM_TGT);

    // R1: a line never matches two entries at once.
    a_r1_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/mshr_cwf_sequencer.sv
// Fill servicer: on an accepted fill, steps through the entry's targets one
// per cycle and produces either a timed response or a prefetch mark.
// Assumes the target count of the serviced entry is stable during service.
module mshr_cwf_sequencer #(
    parameter int NUM_ENT    = 4,
    parameter int NUM_TGT    = 4,
    parameter int LINE_AW    = 26,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 4,
    parameter int DLY_W      = 8,
    parameter int RSP_LAT    = 2,
    parameter int PAY_LAT    = 3,
    localparam int ENT_W = $clog2(NUM_ENT),
    localparam int IDX_W = $clog2(NUM_TGT),
    localparam int CNT_W = $clog2(NUM_TGT + 1),
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic [ENT_W-1:0]   fill_entry,
    input  logic               fill_error,
    input  logic               fill_ent_vld,
    input  logic [CNT_W-1:0]   cur_cnt,
    input  logic [OFF_W-1:0]   cur_off,
    input  logic [OFF_W-1:0]   ref_off,
    input  logic               cur_pf,
    input  logic [TAG_W-1:0]   cur_tag,
    input  logic [LINE_AW-1:0] cur_line,
    output logic               busy,
    output logic [ENT_W-1:0]   svc_ent,
    output logic [IDX_W-1:0]   svc_idx,
    output logic               done,
    output logic               fill_ready,
    output logic               rsp_valid,
    output logic [TAG_W-1:0]   rsp_tag,
    output logic [OFF_W-1:0]   rsp_offset,
    output logic [DLY_W-1:0]   rsp_delay,
    output logic               rsp_error,
    output logic               pf_valid,
    output logic [LINE_AW-1:0] pf_line
);
    logic             err_q;
    logic             last;
    logic [OFF_W-1:0] xfer;

    assign last = (CNT_W'(svc_idx) + CNT_W'(1)) == cur_cnt;
    assign done = busy && last;
    assign fill_ready = !busy;

    // Service state: start on an accepted fill, advance one target per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            svc_ent <= '0;
            svc_idx <= '0;
            err_q   <= 1'b0;
        end else if (!busy) begin
            if (fill_valid && fill_ent_vld) begin
                busy    <= 1'b1;
                svc_ent <= fill_entry;
                svc_idx <= '0;
                err_q   <= fill_error;
            end
        end else begin
            if (last) busy <= 1'b0;
            svc_idx <= svc_idx + IDX_W'(1);
        end
    end

    // Wrapped distance from the critical word; the width makes it modulo the line.
    assign xfer = cur_off - ref_off;

    // Output of the current target.
    always_comb begin
        rsp_valid  = busy && !cur_pf;
        pf_valid   = busy && cur_pf;
        rsp_tag    = cur_tag;
        rsp_offset = cur_off;
        rsp_error  = err_q;
        pf_line    = cur_line;
        rsp_delay  = (xfer == '0) ? DLY_W'(RSP_LAT) : DLY_W'(RSP_LAT + PAY_LAT);
    end

    // R5: a response delay is one of the two legal values.
    a_r5_delay_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_delay == DLY_W'(RSP_LAT) || rsp_delay == DLY_W'(RSP_LAT + PAY_LAT)));
    // R7: no new fill is taken while one is in service.
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy && $stable(svc_ent));
endmodule

// File: rtl/mshr_cwf.sv
// Line-miss tracker top: holds the entries and their ordered target lists,
// answers the allocate/merge lookup, and hands accepted fills to the servicer.
// Assumes one request and one fill per cycle at most.
module mshr_cwf
    import mshr_cwf_pkg::*;
#(
    parameter int NUM_ENT    = 4,
    parameter int NUM_TGT    = 4,
    parameter int LINE_AW    = 26,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 4,
    parameter int DLY_W      = 8,
    parameter int RSP_LAT    = 2,
    parameter int PAY_LAT    = 3,
    localparam int ENT_W = $clog2(NUM_ENT),
    localparam int IDX_W = $clog2(NUM_TGT),
    localparam int CNT_W = $clog2(NUM_TGT + 1),
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [LINE_AW-1:0] req_line,
    input  logic               req_secure,
    input  logic [OFF_W-1:0]   req_offset,
    input  logic [1:0]         req_src,
    input  logic [TAG_W-1:0]   req_tag,
    output logic               req_full,
    output logic [ENT_W-1:0]   req_entry,
    output logic               req_new,
    output logic               src_err,
    input  logic               fill_valid,
    input  logic [ENT_W-1:0]   fill_entry,
    input  logic               fill_error,
    output logic               fill_ready,
    output logic               rsp_valid,
    output logic [TAG_W-1:0]   rsp_tag,
    output logic [OFF_W-1:0]   rsp_offset,
    output logic [DLY_W-1:0]   rsp_delay,
    output logic               rsp_error,
    output logic               pf_valid,
    output logic [LINE_AW-1:0] pf_line
);
    logic               ent_vld  [NUM_ENT];
    logic [LINE_AW-1:0] ent_line [NUM_ENT];
    logic               ent_sec  [NUM_ENT];
    logic [CNT_W-1:0]   ent_cnt  [NUM_ENT];
    logic [OFF_W-1:0]   tgt_off  [NUM_ENT][NUM_TGT];
    logic               tgt_pf   [NUM_ENT][NUM_TGT];
    logic [TAG_W-1:0]   tgt_tag  [NUM_ENT][NUM_TGT];

    logic             hit, hit_full, has_free, is_snoop, accept;
    logic [ENT_W-1:0] hit_ent, free_ent, svc_ent;
    logic [IDX_W-1:0] svc_idx;
    logic             svc_busy, svc_done;

    mshr_cwf_lookup #(.NUM_ENT(NUM_ENT), .NUM_TGT(NUM_TGT), .LINE_AW(LINE_AW)) u_lookup (
        .clk(clk), .rst_n(rst_n),
        .ent_vld(ent_vld), .ent_line(ent_line), .ent_sec(ent_sec), .ent_cnt(ent_cnt),
        .svc_busy(svc_busy), .svc_ent(svc_ent),
        .q_line(req_line), .q_sec(req_secure),
        .hit(hit), .hit_ent(hit_ent), .hit_slots_full(hit_full),
        .has_free(has_free), .free_ent(free_ent)
    );

    // Request decision: merge, allocate or stall.
    always_comb begin
        is_snoop  = req_src == SRC_SNOOP;
        req_new   = !hit;
        req_entry = hit ? hit_ent : free_ent;
        req_full  = hit ? hit_full : !has_free;
        accept    = req_valid && !req_full && !is_snoop;
    end

    // Flag an illegal snoop-source request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) src_err <= 1'b0;
        else        src_err <= req_valid && is_snoop;
    end

    // Per-entry storage: release on service end, allocate or append on accept.
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic [IDX_W-1:0] slot;
        assign slot = req_new ? '0 : ent_cnt[e][IDX_W-1:0];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[e] <= 1'b0;
                ent_cnt[e] <= '0;
            end else if (svc_done && svc_ent == ENT_W'(e)) begin
                ent_vld[e] <= 1'b0;
                ent_cnt[e] <= '0;
            end else if (accept && req_entry == ENT_W'(e)) begin
                if (req_new) begin
                    ent_vld[e]  <= 1'b1;
                    ent_line[e] <= req_line;
                    ent_sec[e]  <= req_secure;
                    ent_cnt[e]  <= CNT_W'(1);
                end else begin
                    ent_cnt[e]  <= ent_cnt[e] + CNT_W'(1);
                end
                tgt_off[e][slot] <= req_offset;
                tgt_pf[e][slot]  <= req_src == SRC_PF;
                tgt_tag[e][slot] <= req_tag;
            end
        end

        // R3: a stalled request leaves this entry's target count alone.
        a_r3_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_full && !(svc_done && svc_ent == ENT_W'(e))) |=> $stable(ent_cnt[e]));
        // R8: a snoop-source request leaves this entry's target count alone.
        a_r8_snoop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && is_snoop && !(svc_done && svc_ent == ENT_W'(e))) |=> $stable(ent_cnt[e]));
    end

    mshr_cwf_sequencer #(
        .NUM_ENT(NUM_ENT), .NUM_TGT(NUM_TGT), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES),
        .TAG_W(TAG_W), .DLY_W(DLY_W), .RSP_LAT(RSP_LAT), .PAY_LAT(PAY_LAT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_entry(fill_entry), .fill_error(fill_error),
        .fill_ent_vld(ent_vld[fill_entry]),
        .cur_cnt(ent_cnt[svc_ent]), .cur_off(tgt_off[svc_ent][svc_idx]),
        .ref_off(tgt_off[svc_ent][0]), .cur_pf(tgt_pf[svc_ent][svc_idx]),
        .cur_tag(tgt_tag[svc_ent][svc_idx]), .cur_line(ent_line[svc_ent]),
        .busy(svc_busy), .svc_ent(svc_ent), .svc_idx(svc_idx), .done(svc_done),
        .fill_ready(fill_ready),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_offset(rsp_offset),
        .rsp_delay(rsp_delay), .rsp_error(rsp_error),
        .pf_valid(pf_valid), .pf_line(pf_line)
    );

    // R2: a fresh allocation holds exactly one target on the next cycle.
    a_r2_alloc_one: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_new) |=> ent_cnt[$past(req_entry)] == CNT_W'(1));
    // R4: the servicer only ever works on a valid entry.
    a_r4_svc_valid: assert property (@(posedge clk) disable iff (!rst_n)
        svc_busy |-> ent_vld[svc_ent]);
    // R7: the entry is released right after its last target.
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |=> !ent_vld[$past(svc_ent)]);
endmodule

// File: tb/tb_mshr_cwf.sv
`timescale 1ns/1ps
module tb_mshr_cwf;
    localparam int NE = 4, NT = 4, LA = 26, LB = 64, TW = 4, DW = 8, RL = 2, PL = 3;
    localparam int OW = $clog2(LB), EW = $clog2(NE);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_secure = 0, fill_valid = 0, fill_error = 0;
    logic [LA-1:0] req_line = '0;
    logic [OW-1:0] req_offset = '0;
    logic [1:0] req_src = '0;
    logic [TW-1:0] req_tag = '0;
    logic [EW-1:0] fill_entry = '0;
    logic req_full, req_new, src_err, fill_ready, rsp_valid, rsp_error, pf_valid;
    logic [EW-1:0] req_entry;
    logic [TW-1:0] rsp_tag;
    logic [OW-1:0] rsp_offset;
    logic [DW-1:0] rsp_delay;
    logic [LA-1:0] pf_line;

    mshr_cwf dut (.*);

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit ended = 0;

    // Expected-state model of the entries.
    bit          m_vld [NE];
    bit [LA-1:0] m_line[NE];
    bit          m_sec [NE];
    int          m_cnt [NE];
    bit [OW-1:0] m_off [NE][NT];
    bit          m_pf  [NE][NT];
    bit [TW-1:0] m_tag [NE][NT];
    int          m_busy = -1;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic predict(input bit [LA-1:0] l, input bit s, output bit full, output bit nw, output int ent);
        int h = -1, f = -1;
        for (int e = 0; e < NE; e++) begin
            if (h < 0 && m_vld[e] && e != m_busy && m_line[e] == l && m_sec[e] == s) h = e;
            if (f < 0 && !m_vld[e]) f = e;
        end
        if (h >= 0) begin full = (m_cnt[h] == NT); nw = 0; ent = h; end
        else        begin full = (f < 0); nw = 1; ent = (f < 0) ? 0 : f; end
    endtask

    task automatic apply(input int e, input bit nw, input bit [LA-1:0] l, input bit s,
                         input bit [OW-1:0] o, input bit pf, input bit [TW-1:0] t);
        if (nw) begin m_vld[e] = 1; m_line[e] = l; m_sec[e] = s; m_cnt[e] = 0; end
        m_off[e][m_cnt[e]] = o; m_pf[e][m_cnt[e]] = pf; m_tag[e][m_cnt[e]] = t;
        m_cnt[e]++;
    endtask

    task automatic drive_req(input bit [LA-1:0] l, input bit s, input bit [OW-1:0] o,
                             input bit [1:0] src, input bit [TW-1:0] t);
        req_valid = 1; req_line = l; req_secure = s; req_offset = o; req_src = src; req_tag = t;
    endtask

    // Check the lookup result of the request currently driven; R1, R2, R3.
    task automatic check_lookup(output bit full, output bit nw, output int ent);
        predict(req_line, req_secure, full, nw, ent);
        chk("R3 full", req_full, full);
        if (!full) begin
            chk(nw ? "R2 new" : "R1 new", req_new, nw);
            chk(nw ? "R2 entry" : "R1 entry", req_entry, ent);
        end
    endtask

    task automatic do_req(input bit [LA-1:0] l, input bit s, input bit [OW-1:0] o,
                          input bit [1:0] src, input bit [TW-1:0] t);
        bit full, nw; int ent;
        @(negedge clk);
        fill_valid = 0;
        drive_req(l, s, o, src, t);
        #1;
        if (src == 2) begin
            @(posedge clk);
            @(negedge clk);
            req_valid = 0;
            #1 chk("R8 src_err", src_err, 1);
        end else begin
            check_lookup(full, nw, ent);
            @(posedge clk);
            if (!full) apply(ent, nw, l, s, o, src == 1, t);
        end
    endtask

    task automatic do_fill(input int e, input bit err, input bit mid, input bit [OW-1:0] moff,
                           input bit [TW-1:0] mtag);
        int n; bit v; bit full, nw; int ent;
        @(negedge clk);
        req_valid = 0;
        fill_valid = 1; fill_entry = EW'(e); fill_error = err;
        #1 chk("R7 ready before fill", fill_ready, 1);
        v = m_vld[e]; n = m_cnt[e];
        @(posedge clk);
        @(negedge clk);
        fill_valid = 0;
        if (!v) begin
            #1;
            chk("R11 no rsp", rsp_valid, 0);
            chk("R11 no pf", pf_valid, 0);
            chk("R11 ready", fill_ready, 1);
            return;
        end
        m_busy = e;
        for (int k = 0; k < n; k++) begin
            bit [OW-1:0] xf;
            if (k == 0 && mid) drive_req(m_line[e], m_sec[e], moff, 2'd0, mtag);
            #1;
            chk("R7 busy", fill_ready, 0);
            if (m_pf[e][k]) begin
                chk("R6 pf_valid", pf_valid, 1);
                chk("R6 no rsp", rsp_valid, 0);
                chk("R6 pf_line", pf_line, m_line[e]);
            end else begin
                xf = m_off[e][k] - m_off[e][0];
                chk("R4 rsp_valid", rsp_valid, 1);
                chk("R4 rsp_tag", rsp_tag, m_tag[e][k]);
                chk("R4 rsp_offset", rsp_offset, m_off[e][k]);
                chk("R5 rsp_delay", rsp_delay, (xf == 0) ? RL : RL + PL);
                chk("R9 rsp_error", rsp_error, err);
            end
            if (k == 0 && mid) begin
                check_lookup(full, nw, ent);
                chk("R10 not merged", req_new, 1);
            end
            @(posedge clk);
            if (k == 0 && mid && !full) apply(ent, nw, m_line[e], m_sec[e], moff, 0, mtag);
            @(negedge clk);
            req_valid = 0;
        end
        #1;
        chk("R7 idle rsp", rsp_valid, 0);
        chk("R7 idle pf", pf_valid, 0);
        chk("R7 ready after", fill_ready, 1);
        m_vld[e] = 0; m_cnt[e] = 0; m_busy = -1;
    endtask

    initial begin
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit [LA-1:0] la, lb, lc;
        void'($urandom(32'h5eed_1234));
        for (int e = 0; e < NE; e++) begin m_vld[e] = 0; m_cnt[e] = 0; end
        la = 26'h100; lb = 26'h101; lc = 26'h102;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk("reset fill_ready", fill_ready, 1);
        chk("reset rsp_valid", rsp_valid, 0);
        chk("reset pf_valid", pf_valid, 0);
        chk("reset src_err", src_err, 0);
        chk("reset req_full", req_full, 0);

        // Four targets into one line, then a fifth stalls (R1, R2, R3).
        do_req(la, 0, 6'd8, 0, 4'h1);
        do_req(la, 0, 6'd40, 0, 4'h2);
        do_req(la, 0, 6'd0, 1, 4'h3);
        do_req(la, 0, 6'd4, 0, 4'h4);
        do_req(la, 0, 6'd9, 0, 4'h5);
        do_req(la, 1, 6'd3, 0, 4'h6);
        do_req(lb, 0, 6'd63, 0, 4'h7);
        do_req(lb, 0, 6'd0, 0, 4'h8);
        // Snoop source rejected and not stored (R8).
        do_req(lb, 0, 6'd1, 2, 4'h9);
        // Wrapped offsets, prefetch target, release (R4, R5, R6, R7).
        do_fill(0, 0, 0, 0, 0);
        // Fill error copied, mid-service request to the serviced line (R9, R10).
        do_fill(2, 1, 0, 0, 0);
        do_fill(1, 1, 1, 6'd5, 4'hA);
        // Fill to an invalid entry (R11).
        do_fill(3, 0, 0, 0, 0);
        // Exhaust the entries (R3).
        do_req(la, 0, 6'd1, 0, 4'h1);
        do_req(lc, 0, 6'd2, 0, 4'h2);
        do_req(lc, 1, 6'd3, 0, 4'h3);
        do_req(lb, 1, 6'd4, 0, 4'h4);
        for (int e = 0; e < NE; e++) do_fill(e, 0, 0, 0, 0);

        // Random mix against the model.
        for (int it = 0; it < 600; it++) begin
            int op = $urandom % 10;
            if (op < 3) begin
                do_fill($urandom % NE, ($urandom % 8) == 0, ($urandom % 4) == 0,
                        OW'($urandom), TW'($urandom));
            end else begin
                int sr = $urandom % 20;
                do_req(la + LA'($urandom % 3), $urandom % 2, OW'($urandom),
                       (sr == 0) ? 2'd2 : (sr < 4) ? 2'd1 : 2'd0, TW'($urandom));
            end
        end
        @(negedge clk);
        req_valid = 0; fill_valid = 0;
        finish_run();
    end
endmodule